// File: doc/BRIEF.md
# Privileged Status and Exception-Return Controller

This block keeps the privileged control state of a processor core. That state is a 32-bit status word with an interrupt-enable bit, an exception-level bit and an error-level bit. It also holds a debug-mode flag and three saved return addresses, one for exceptions, one for errors and one for debug. The decode stage sends it one command per cycle.

Two commands read and then change interrupt enabling. Each of them hands back the status word as it was before the command. The other two commands are returns. Each return produces a one-cycle redirect with the target PC, and updates the mode bits. Each return also invalidates the load-linked reservation by forcing the link address register to 1. Any change to the control state raises a one-cycle "flags recomputed" strobe. The interrupt-request and kernel-mode outputs always follow the current state.

A simple write port loads the status word and the three return addresses. Separate inputs enter debug mode and set the link address. Exception entry, interrupt arbitration and pipeline flushing are handled elsewhere.

Top module: `psr_ctrl`

## Requirements
- R1: After reset the status word is 0x0000_0004 (only the error-level bit, bit 2, is set). Debug mode is off, the link address is 0, and redirect_valid, old_status_valid and flags_upd are low.
- R2: Command code 0 (disable interrupts) puts the previous status word on old_status, with old_status_valid high for one cycle. It then clears only bit 0 (interrupt enable).
- R3: Command code 1 (enable interrupts) puts the previous status word on old_status, with old_status_valid high for one cycle. It then sets only bit 0.
- R4: Command code 2 (exception return) with bit 2 (error level) set redirects to the error-return address. It clears only bit 2.
- R5: Command code 2 with bit 2 clear redirects to the exception-return address and clears bit 1 (exception level). This also holds when bit 1 is already clear.
- R6: Command code 3 (debug return) redirects to the debug-return address and clears debug mode. It leaves the status word unchanged.
- R7: Both return commands set the link address to 1. This takes priority over an ll_set in the same cycle.
- R8: Each return command gives exactly one cycle of redirect_valid, in the cycle after the command is sampled. All state updates take effect on that same clock edge. The other commands never raise redirect_valid.
- R9: flags_upd is high for one cycle after any cycle that holds a command, a status write or a debug entry. It is low otherwise.
- R10: irq_req is high when any irq_lines bit is set and bit 0 is set, bits 1 and 2 are clear and debug mode is off. kernel_mode is the OR of bit 1, bit 2 and debug mode. Both outputs follow state and inputs with no register delay.
- R11: wr_sel selects 0 = status word, 1 = exception-return address, 2 = error-return address, 3 = debug-return address. A status write in the same cycle as a command is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 2 | Command code: 0 disable, 1 enable, 2 exception return, 3 debug return |
| wr_en | input | 1 | Write strobe for the status word or a return address |
| wr_sel | input | 2 | Write target selector |
| wr_data | input | 32 | Write data |
| dbg_enter | input | 1 | Enter debug mode |
| ll_set | input | 1 | Load a new link address |
| ll_wdata | input | 32 | Link address to load |
| irq_lines | input | 8 | Raw interrupt request lines |
| status | output | 32 | Current status word |
| debug_mode | output | 1 | Debug mode flag |
| kernel_mode | output | 1 | Derived privileged-mode flag |
| irq_req | output | 1 | Interrupt request to the core |
| old_status_valid | output | 1 | old_status holds a result |
| old_status | output | 32 | Status word before the last enable/disable command |
| flags_upd | output | 1 | Derived flags were recomputed |
| redirect_valid | output | 1 | Redirect pulse |
| redirect_pc | output | 32 | Redirect target |
| ll_addr | output | 32 | Load-linked address register |

## Verification
Every registered result appears in the first cycle after the edge that samples the command or write. These results are status, debug_mode, old_status, redirect, flags_upd and ll_addr. The bench drives stimulus at the falling edge. It samples one time unit after the next rising edge, which is the single register stage. It also samples once more a cycle later to show that the pulses have dropped. irq_req and kernel_mode are combinational. They are checked in that same post-edge window, against the state just written.

// File: rtl/psr_pkg.sv
// Package: shared encodings for the privileged status controller.
// Assumes a status word of at least three bits; bit positions are fixed.
package psr_pkg;
    typedef enum logic [1:0] {
        OP_DI    = 2'd0,
        OP_EI    = 2'd1,
        OP_ERET  = 2'd2,
        OP_DERET = 2'd3
    } psr_op_e;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_EXC    = 2'd1,
        SEL_ERR    = 2'd2,
        SEL_DBG    = 2'd3
    } psr_sel_e;

    localparam int IE_BIT  = 0;
    localparam int EXL_BIT = 1;
    localparam int ERL_BIT = 2;

    // Number of saved return addresses.
    localparam int N_RET = 3;
endpackage

// File: rtl/psr_status.sv
// Module: psr_status
// Holds the status word and debug flag, applies commands and status
// writes, captures the pre-command word for enable/disable, and derives
// the interrupt request and kernel-mode flags.
// Assumes: a command in the same cycle as a status write wins.
module psr_status
    import psr_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IRQ_N = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic             wr_status,
    input  logic [XLEN-1:0]  wdata,
    input  logic             dbg_enter,
    input  logic [IRQ_N-1:0] irq_lines,
    output logic [XLEN-1:0]  status_q,
    output logic             debug_q,
    output logic [XLEN-1:0]  old_q,
    output logic             old_valid_q,
    output logic             flags_upd_q,
    output logic             use_err,
    output logic             irq_req,
    output logic             kernel_mode
);
    localparam logic [XLEN-1:0] RST_STATUS = XLEN'(1) << ERL_BIT;
    localparam logic [XLEN-1:0] ERL_MASK   = XLEN'(1) << ERL_BIT;
    localparam logic [XLEN-1:0] EXL_MASK   = XLEN'(1) << EXL_BIT;

    psr_op_e         op;
    logic [XLEN-1:0] st_d;
    logic            dbg_d;
    logic            is_ie_cmd;

    assign op        = psr_op_e'(cmd_op);
    assign is_ie_cmd = cmd_valid && (op == OP_DI || op == OP_EI);

    // Next-state computation for status word and debug flag.
    always_comb begin
        st_d  = status_q;
        dbg_d = debug_q;
        if (cmd_valid) begin
            case (op)
                OP_DI:   st_d[IE_BIT] = 1'b0;
                OP_EI:   st_d[IE_BIT] = 1'b1;
                OP_ERET: begin
                    if (status_q[ERL_BIT]) st_d[ERL_BIT] = 1'b0;
                    else                   st_d[EXL_BIT] = 1'b0;
                end
                default: dbg_d = 1'b0;
            endcase
        end else if (wr_status) begin
            st_d = wdata;
        end
        if (dbg_enter && !(cmd_valid && op == OP_DERET)) dbg_d = 1'b1;
    end

    // State, captured old word and strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q    <= RST_STATUS;
            debug_q     <= 1'b0;
            old_q       <= '0;
            old_valid_q <= 1'b0;
            flags_upd_q <= 1'b0;
        end else begin
            status_q    <= st_d;
            debug_q     <= dbg_d;
            old_valid_q <= is_ie_cmd;
            if (is_ie_cmd) old_q <= status_q;
            flags_upd_q <= cmd_valid || wr_status || dbg_enter;
        end
    end

    // Derived flags from the current state.
    assign use_err     = status_q[ERL_BIT];
    assign kernel_mode = status_q[EXL_BIT] | status_q[ERL_BIT] | debug_q;
    assign irq_req     = (|irq_lines) & status_q[IE_BIT] & ~kernel_mode;

    AST_DI_CLEARS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_DI) |=> !status_q[IE_BIT]); // R2
    AST_EI_SETS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_EI) |=> status_q[IE_BIT]); // R3
    AST_ERET_ERR_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_ERET && status_q[ERL_BIT])
        |=> status_q == ($past(status_q) & ~ERL_MASK)); // R4
    AST_ERET_EXC_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_ERET && !status_q[ERL_BIT])
        |=> status_q == ($past(status_q) & ~EXL_MASK)); // R5
    AST_DERET_LEAVES_DEBUG: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_DERET) |=> (!debug_q && $stable(status_q))); // R6
    AST_FLAGS_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> flags_upd_q); // R9
endmodule

// File: rtl/psr_retaddr.sv
// Module: psr_retaddr
// Bank of saved return addresses (exception, error, debug), each loaded
// by the write port when the selector names it.
// Assumes: selector codes 1..N_RET map to bank entries 0..N_RET-1.
module psr_retaddr
    import psr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      wr_sel,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] exc_pc,
    output logic [XLEN-1:0] err_pc,
    output logic [XLEN-1:0] dbg_pc
);
    logic [XLEN-1:0] addr_q [N_RET];

    for (genvar i = 0; i < N_RET; i++) begin : g_bank
        // Load one entry when its selector code is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                addr_q[i] <= '0;
            else if (wr_en && wr_sel == 2'(i + 1))
                addr_q[i] <= wdata;
        end
    end

    assign exc_pc = addr_q[int'(SEL_EXC) - 1];
    assign err_pc = addr_q[int'(SEL_ERR) - 1];
    assign dbg_pc = addr_q[int'(SEL_DBG) - 1];
endmodule

// File: rtl/psr_redirect.sv
// Module: psr_redirect
// Registers the redirect pulse and target for return commands and owns
// the load-linked address, which every return forces to 1.
// Assumes: use_err reflects the status word before the command edge.
module psr_redirect
    import psr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [1:0]      cmd_op,
    input  logic            use_err,
    input  logic [XLEN-1:0] exc_pc,
    input  logic [XLEN-1:0] err_pc,
    input  logic [XLEN-1:0] dbg_pc,
    input  logic            ll_set,
    input  logic [XLEN-1:0] ll_wdata,
    output logic            redirect_valid_q,
    output logic [XLEN-1:0] redirect_pc_q,
    output logic [XLEN-1:0] ll_addr_q
);
    localparam logic [XLEN-1:0] LL_KILL = XLEN'(1);

    psr_op_e         op;
    logic            is_ret;
    logic [XLEN-1:0] target;

    assign op     = psr_op_e'(cmd_op);
    assign is_ret = cmd_valid && (op == OP_ERET || op == OP_DERET);

    // Target selection: debug, then error-level priority, else exception.
    always_comb begin
        if (op == OP_DERET)  target = dbg_pc;
        else if (use_err)    target = err_pc;
        else                 target = exc_pc;
    end

    // Redirect pulse, target and link address register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_valid_q <= 1'b0;
            redirect_pc_q    <= '0;
            ll_addr_q        <= '0;
        end else begin
            redirect_valid_q <= is_ret;
            if (is_ret) redirect_pc_q <= target;
            if (is_ret)      ll_addr_q <= LL_KILL;
            else if (ll_set) ll_addr_q <= ll_wdata;
        end
    end

    AST_REDIRECT_FROM_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid_q |-> $past(cmd_valid && cmd_op[1])); // R8
    AST_RETURN_KILLS_LL: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid_q |-> ll_addr_q == LL_KILL); // R7
endmodule

// File: rtl/psr_ctrl.sv
// Module: psr_ctrl (top)
// Privileged status and exception-return controller: status word,
// debug flag, return-address bank, redirect and link-address handling.
// Assumes: at most one command per cycle from decode.
module psr_ctrl
    import psr_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IRQ_N = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [XLEN-1:0]  wr_data,
    input  logic             dbg_enter,
    input  logic             ll_set,
    input  logic [XLEN-1:0]  ll_wdata,
    input  logic [IRQ_N-1:0] irq_lines,
    output logic [XLEN-1:0]  status,
    output logic             debug_mode,
    output logic             kernel_mode,
    output logic             irq_req,
    output logic             old_status_valid,
    output logic [XLEN-1:0]  old_status,
    output logic             flags_upd,
    output logic             redirect_valid,
    output logic [XLEN-1:0]  redirect_pc,
    output logic [XLEN-1:0]  ll_addr
);
    logic            wr_status;
    logic            use_err;
    logic [XLEN-1:0] exc_pc, err_pc, dbg_pc;

    assign wr_status = wr_en && (psr_sel_e'(wr_sel) == SEL_STATUS);

    psr_status #(.XLEN(XLEN), .IRQ_N(IRQ_N)) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .wr_status   (wr_status),
        .wdata       (wr_data),
        .dbg_enter   (dbg_enter),
        .irq_lines   (irq_lines),
        .status_q    (status),
        .debug_q     (debug_mode),
        .old_q       (old_status),
        .old_valid_q (old_status_valid),
        .flags_upd_q (flags_upd),
        .use_err     (use_err),
        .irq_req     (irq_req),
        .kernel_mode (kernel_mode)
    );

    psr_retaddr #(.XLEN(XLEN)) u_retaddr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_sel (wr_sel),
        .wdata  (wr_data),
        .exc_pc (exc_pc),
        .err_pc (err_pc),
        .dbg_pc (dbg_pc)
    );

    psr_redirect #(.XLEN(XLEN)) u_redirect (
        .clk              (clk),
        .rst_n            (rst_n),
        .cmd_valid        (cmd_valid),
        .cmd_op           (cmd_op),
        .use_err          (use_err),
        .exc_pc           (exc_pc),
        .err_pc           (err_pc),
        .dbg_pc           (dbg_pc),
        .ll_set           (ll_set),
        .ll_wdata         (ll_wdata),
        .redirect_valid_q (redirect_valid),
        .redirect_pc_q    (redirect_pc),
        .ll_addr_q        (ll_addr)
    );

    AST_REDIRECT_NOT_ON_IE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        old_status_valid |-> !redirect_valid); // R8
endmodule

// File: tb/psr_ctrl_bench.sv
module psr_ctrl_bench;
    localparam logic [31:0] EXC = 32'h1000_0100;
    localparam logic [31:0] ERR = 32'h1000_0200;
    localparam logic [31:0] DBG = 32'h1000_0300;

    typedef struct packed {
        logic        wr;
        logic [1:0]  sel;
        logic [31:0] wdata;
        logic        cv;
        logic [1:0]  op;
        logic [31:0] st;
        logic        rv;
        logic [31:0] pc;
        logic        ov;
        logic [31:0] old;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 2'd0, 32'h0, 1'b1, 2'd0, 32'h4,         1'b0, 32'h0, 1'b1, 32'h4,         4'd2},  // R2
        '{1'b0, 2'd0, 32'h0, 1'b1, 2'd1, 32'h5,         1'b0, 32'h0, 1'b1, 32'h4,         4'd3},  // R3
        '{1'b0, 2'd0, 32'h0, 1'b1, 2'd2, 32'h1,         1'b1, ERR,   1'b0, 32'h0,         4'd4},  // R4
        '{1'b1, 2'd0, 32'h3, 1'b0, 2'd0, 32'h3,         1'b0, 32'h0, 1'b0, 32'h0,         4'd11}, // R11
        '{1'b0, 2'd0, 32'h0, 1'b1, 2'd2, 32'h1,         1'b1, EXC,   1'b0, 32'h0,         4'd5},  // R5
        '{1'b0, 2'd0, 32'h0, 1'b1, 2'd2, 32'h1,         1'b1, EXC,   1'b0, 32'h0,         4'd5},  // R5 neither level set
        '{1'b1, 2'd0, 32'h6, 1'b0, 2'd0, 32'h6,         1'b0, 32'h0, 1'b0, 32'h0,         4'd11}, // R11
        '{1'b0, 2'd0, 32'h0, 1'b1, 2'd2, 32'h2,         1'b1, ERR,   1'b0, 32'h0,         4'd4},  // R4 both set
        '{1'b0, 2'd0, 32'h0, 1'b1, 2'd2, 32'h0,         1'b1, EXC,   1'b0, 32'h0,         4'd5},  // R5
        '{1'b0, 2'd0, 32'h0, 1'b1, 2'd0, 32'h0,         1'b0, 32'h0, 1'b1, 32'h0,         4'd2},  // R2
        '{1'b1, 2'd0, 32'hA5A5_0001, 1'b0, 2'd0, 32'hA5A5_0001, 1'b0, 32'h0, 1'b0, 32'h0, 4'd11}, // R11
        '{1'b0, 2'd0, 32'h0, 1'b1, 2'd0, 32'hA5A5_0000, 1'b0, 32'h0, 1'b1, 32'hA5A5_0001, 4'd2},  // R2
        '{1'b0, 2'd0, 32'h0, 1'b1, 2'd1, 32'hA5A5_0001, 1'b0, 32'h0, 1'b1, 32'hA5A5_0000, 4'd3},  // R3
        '{1'b1, 2'd0, 32'hFF, 1'b1, 2'd0, 32'hA5A5_0000, 1'b0, 32'h0, 1'b1, 32'hA5A5_0001, 4'd11} // R11 write dropped
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        dbg_enter = 1'b0;
    logic        ll_set = 1'b0;
    logic [31:0] ll_wdata = '0;
    logic [7:0]  irq_lines = '0;
    logic [31:0] status, old_status, redirect_pc, ll_addr;
    logic        debug_mode, kernel_mode, irq_req, old_status_valid;
    logic        flags_upd, redirect_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    psr_ctrl u_psr_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .dbg_enter(dbg_enter), .ll_set(ll_set), .ll_wdata(ll_wdata),
        .irq_lines(irq_lines), .status(status), .debug_mode(debug_mode),
        .kernel_mode(kernel_mode), .irq_req(irq_req),
        .old_status_valid(old_status_valid), .old_status(old_status),
        .flags_upd(flags_upd), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .ll_addr(ll_addr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one cycle of stimulus at the falling edge; return just after the rising edge.
    task automatic step(input logic wr, input logic [1:0] sel, input logic [31:0] wd,
                        input logic cv, input logic [1:0] op,
                        input logic de, input logic ls, input logic [31:0] lw);
        @(negedge clk);
        wr_en = wr; wr_sel = sel; wr_data = wd;
        cmd_valid = cv; cmd_op = op;
        dbg_enter = de; ll_set = ls; ll_wdata = lw;
        @(posedge clk);
        #1;
        wr_en = 1'b0; cmd_valid = 1'b0; dbg_enter = 1'b0; ll_set = 1'b0;
    endtask

    task automatic idle();
        step(1'b0, 2'd0, 32'h0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 status", status, 32'h4);
        chk("R1 debug", 32'(debug_mode), 32'h0);
        chk("R1 ll_addr", ll_addr, 32'h0);
        chk("R1 pulses", {29'h0, redirect_valid, old_status_valid, flags_upd}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R11 load return addresses
        step(1'b1, 2'd1, EXC, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0);
        step(1'b1, 2'd2, ERR, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0);
        step(1'b1, 2'd3, DBG, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0);
        chk("R9 no strobe on address write", 32'(flags_upd), 32'h0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            step(TBL[i].wr, TBL[i].sel, TBL[i].wdata, TBL[i].cv, TBL[i].op,
                 1'b0, 1'b0, 32'h0);
            chk($sformatf("R%0d row %0d status", TBL[i].req, i), status, TBL[i].st);
            chk($sformatf("R8 row %0d redirect_valid", i), 32'(redirect_valid), 32'(TBL[i].rv));
            if (TBL[i].rv)
                chk($sformatf("R%0d row %0d redirect_pc", TBL[i].req, i), redirect_pc, TBL[i].pc);
            chk($sformatf("R%0d row %0d old_valid", TBL[i].req, i), 32'(old_status_valid), 32'(TBL[i].ov));
            if (TBL[i].ov)
                chk($sformatf("R%0d row %0d old_status", TBL[i].req, i), old_status, TBL[i].old);
            chk($sformatf("R9 row %0d flags_upd", i), 32'(flags_upd),
                32'(TBL[i].cv | (TBL[i].wr & (TBL[i].sel == 2'd0))));
        end

        // R8 pulse width: an idle cycle drops all pulses
        idle();
        chk("R8 redirect drops", 32'(redirect_valid), 32'h0);
        chk("R9 flags drops", 32'(flags_upd), 32'h0);

        // R10 interrupt request and kernel mode
        step(1'b1, 2'd0, 32'h1, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0);
        irq_lines = 8'h10; #1;
        chk("R10 irq enabled", 32'(irq_req), 32'h1);
        chk("R10 kernel off", 32'(kernel_mode), 32'h0);
        irq_lines = 8'h00; #1;
        chk("R10 no lines", 32'(irq_req), 32'h0);
        irq_lines = 8'h01;
        step(1'b1, 2'd0, 32'h3, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0);
        chk("R10 masked by exl", 32'(irq_req), 32'h0);
        chk("R10 kernel by exl", 32'(kernel_mode), 32'h1);

        // R7 link address kill on exception return, priority over ll_set
        step(1'b0, 2'd0, 32'h0, 1'b0, 2'd0, 1'b0, 1'b1, 32'h0000_1234);
        chk("R7 ll load", ll_addr, 32'h0000_1234);
        step(1'b0, 2'd0, 32'h0, 1'b1, 2'd2, 1'b0, 1'b1, 32'h0000_5678);
        chk("R7 eret kills ll", ll_addr, 32'h1);
        chk("R5 eret pc", redirect_pc, EXC);

        // R6 debug entry and debug return
        step(1'b0, 2'd0, 32'h0, 1'b0, 2'd0, 1'b1, 1'b1, 32'h0000_9ABC);
        chk("R6 debug set", 32'(debug_mode), 32'h1);
        chk("R9 strobe on debug entry", 32'(flags_upd), 32'h1);
        chk("R10 kernel by debug", 32'(kernel_mode), 32'h1);
        #1;
        chk("R10 masked by debug", 32'(irq_req), 32'h0);
        step(1'b0, 2'd0, 32'h0, 1'b1, 2'd3, 1'b0, 1'b0, 32'h0);
        chk("R6 deret pc", redirect_pc, DBG);
        chk("R6 deret valid", 32'(redirect_valid), 32'h1);
        chk("R6 debug cleared", 32'(debug_mode), 32'h0);
        chk("R6 status unchanged", status, 32'h1);
        chk("R7 deret kills ll", ll_addr, 32'h1);
        #1;
        chk("R10 irq after deret", 32'(irq_req), 32'h1);

        // R11 reloaded exception address used by next return
        step(1'b1, 2'd1, 32'h2000_0040, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0);
        step(1'b0, 2'd0, 32'h0, 1'b1, 2'd2, 1'b0, 1'b0, 32'h0);
        chk("R11 new exc addr", redirect_pc, 32'h2000_0040);

        // R1 reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R1 status after reset", status, 32'h4);
        chk("R1 ll after reset", ll_addr, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 2'd0, 32'h0, 1'b1, 2'd2, 1'b0, 1'b0, 32'h0);
        chk("R4 addr bank reset", redirect_pc, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule